// File: doc/BRIEF.md
# Sign-Only Crossbar Training Sequencer

This block drives the training of an associative memory whose weights sit in two non-negative matrices: one holds the excitatory part of the weights and the other the inhibitory part. After a start pulse it asks the arrays to move every weight to a mid-range value. It then picks a prototype that has not yet been learned and asks the recall datapath to process it. The recall datapath returns a three-valued error for each bit.

When the error vector is all zero, the prototype counts as learned and a run counter grows. When any bit is in error, the run counter and the learned set are both cleared. The sequencer then sweeps the columns in ascending order and issues one update command for each column that carries an error, always to one matrix per pass. Each command carries a per-row drive pattern. That pattern is the stored prototype or its bitwise complement, chosen only from the signs of the error and of the input. Training ends when the run counter reaches the number of prototypes.

Prototype selection starts from a pseudo-random index and scans forward, wrapping around, to the first prototype that is not yet learned. The prototype store is read combinationally at `pat_addr`.

Top module: `crossbar_train_seq`

## Requirements
- R1: After reset the block is idle: `rcl_req`, `upd_valid`, `wt_init`, `busy` and `done` are all low.
- R2: A `start` pulse seen while idle or done produces exactly one cycle of `wt_init` in the following cycle. It also empties the learned set, zeroes the run counter, raises `busy` and lowers `done`.
- R3: `rcl_req` stays high, with `pat_addr` held steady, until the cycle in which `rcl_ack` is high. Prototype bit value 1 stands for +1 and bit value 0 stands for -1.
- R4: Each bit's error comes from `err_pos` and `err_neg`: `err_pos`=1 means +1, whatever `err_neg` holds; otherwise `err_neg`=1 means -1; both low means 0. An acknowledge whose error vector is all zero marks that prototype learned, adds one to the run counter, and causes no update command.
- R5: While the run counter is non-zero, `pat_addr` never names a learned prototype. It is always below NPAT.
- R6: An acknowledge carrying any non-zero error empties the learned set and zeroes the run counter. It is followed by update commands, one per cycle, for exactly the columns whose error is non-zero, in ascending column order. All of these commands come before the next recall request.
- R7: Drive polarity: with `upd_sel`=0 (excitatory matrix), `upd_drive` equals the prototype when the column error is +1 and its complement when it is -1. With `upd_sel`=1 (inhibitory matrix) the two cases swap.
- R8: The first tuning pass after a start uses `upd_sel`=0. Each later pass uses the other matrix from the pass before it.
- R9: When the run counter reaches NPAT, `done` rises and `busy` falls. No further recall request or update command is issued until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run |
| wt_init | output | 1 | One-cycle request to set all weights mid-range |
| pat_addr | output | IW | Index of the prototype under recall |
| pat_data | input | NBITS | Prototype word read at `pat_addr` |
| rcl_req | output | 1 | Recall request |
| rcl_ack | input | 1 | Recall done; error inputs valid |
| err_pos | input | NBITS | Per-bit +1 error flags |
| err_neg | input | NBITS | Per-bit -1 error flags |
| upd_valid | output | 1 | Update command valid this cycle |
| upd_sel | output | 1 | Target matrix: 0 excitatory, 1 inhibitory |
| upd_col | output | CW | Column being updated |
| upd_drive | output | NBITS | Per-row drive: 1 raises the weight, 0 lowers it |
| busy | output | 1 | Training in progress |
| done | output | 1 | All prototypes learned in one run |

## Verification
The assertions assume the following about the inputs. `rcl_ack` is high only while `rcl_req` is high. The error inputs matter only in the acknowledge cycle. `pat_data` follows `pat_addr` with no delay.

The bench keeps to these assumptions in several ways. Its recall responder raises the acknowledge for a single cycle, after a random wait of zero to two cycles, only while a request is pending. It serves the prototype word combinationally from its own array. It drives the error flags only together with the acknowledge. The error patterns come from `$urandom` under a fixed seed, mixed with directed cases: every bit at -1, bits with both flags set, and an error on the last prototype needed.

// File: rtl/crossbar_train_seq.sv
module crossbar_train_seq #(
  parameter int NPAT  = 6,
  parameter int NBITS = 8,
  localparam int IW = (NPAT  > 1) ? $clog2(NPAT)  : 1,
  localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int SW = $clog2(NPAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             wt_init,
  output logic [IW-1:0]    pat_addr,
  input  logic [NBITS-1:0] pat_data,
  output logic             rcl_req,
  input  logic             rcl_ack,
  input  logic [NBITS-1:0] err_pos,
  input  logic [NBITS-1:0] err_neg,
  output logic             upd_valid,
  output logic             upd_sel,
  output logic [CW-1:0]    upd_col,
  output logic [NBITS-1:0] upd_drive,
  output logic             busy,
  output logic             done
);
  typedef enum logic [2:0] {S_IDLE, S_INIT, S_PICK, S_REQ, S_UPD, S_DONE} st_t;

  st_t             st;
  logic [7:0]      lfsr;
  logic [NPAT-1:0] learned;
  logic [SW-1:0]   run;
  logic            odd;
  logic [IW-1:0]   idx, pick;
  logic [CW-1:0]   col;
  logic [NBITS-1:0] pat_q, ep_q, en_q;

  wire err_any = |(err_pos | err_neg);
  wire col_hit = ep_q[col] | en_q[col];
  wire last_col = (col == CW'(NBITS - 1));

  always_comb begin
    int base, t;
    logic found;
    base  = int'(lfsr) % NPAT;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NPAT; k++) begin
      t = base + k;
      if (t >= NPAT) t = t - NPAT;
      if (!found && !learned[t]) begin
        pick  = IW'(t);
        found = 1'b1;
      end
    end
  end

  assign wt_init   = (st == S_INIT);
  assign rcl_req   = (st == S_REQ);
  assign pat_addr  = idx;
  assign upd_valid = (st == S_UPD) && col_hit;
  assign upd_sel   = ~odd;
  assign upd_col   = col;
  assign upd_drive = (ep_q[col] ^ upd_sel) ? pat_q : ~pat_q;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lfsr    <= 8'hA5;
      learned <= '0;
      run     <= '0;
      odd     <= 1'b1;
      idx     <= '0;
      col     <= '0;
      pat_q   <= '0;
      ep_q    <= '0;
      en_q    <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (st)
        S_IDLE, S_DONE: if (start) st <= S_INIT;
        S_INIT: begin
          learned <= '0;
          run     <= '0;
          odd     <= 1'b1;
          st      <= S_PICK;
        end
        S_PICK: begin
          idx <= pick;
          st  <= S_REQ;
        end
        S_REQ: if (rcl_ack) begin
          pat_q <= pat_data;
          ep_q  <= err_pos;
          en_q  <= err_neg & ~err_pos;
          if (!err_any) begin
            learned[idx] <= 1'b1;
            run          <= run + 1'b1;
            st           <= (run + 1'b1 == SW'(NPAT)) ? S_DONE : S_PICK;
          end else begin
            learned <= '0;
            run     <= '0;
            col     <= '0;
            st      <= S_UPD;
          end
        end
        S_UPD: begin
          col <= col + 1'b1;
          if (last_col) begin
            odd <= ~odd;
            st  <= S_PICK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_req && !rcl_ack) |=> (rcl_req && $stable(pat_addr)));
  a_r5_pick_unlearned: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_req |-> (!learned[pat_addr] && (int'(pat_addr) < NPAT)));
  a_r6_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_req && rcl_ack && err_any) |=> (run == '0 && learned == '0 && st == S_UPD));
  a_r4_pass_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_req && rcl_ack && !err_any) |=> !upd_valid);
  a_r9_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run == SW'(NPAT) && !rcl_req && !upd_valid));
  a_r8_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(st == S_UPD)) |-> $stable(upd_sel));
endmodule

// File: tb/crossbar_train_seq_tb_top.sv
module crossbar_train_seq_tb_top;
  localparam int NPAT = 6, NBITS = 8, IW = 3, CW = 3;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, rcl_ack;
  logic [NBITS-1:0] err_pos, err_neg, pat_data, upd_drive;
  logic wt_init, rcl_req, upd_valid, upd_sel, busy, done;
  logic [IW-1:0] pat_addr;
  logic [CW-1:0] upd_col;
  logic [NBITS-1:0] protos [NPAT];

  assign pat_data = (int'(pat_addr) < NPAT) ? protos[pat_addr] : '0;

  crossbar_train_seq #(.NPAT(NPAT), .NBITS(NBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wt_init(wt_init),
    .pat_addr(pat_addr), .pat_data(pat_data), .rcl_req(rcl_req), .rcl_ack(rcl_ack),
    .err_pos(err_pos), .err_neg(err_neg), .upd_valid(upd_valid), .upd_sel(upd_sel),
    .upd_col(upd_col), .upd_drive(upd_drive), .busy(busy), .done(done));

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc++;

  int streak, qlen, qhead;
  logic [NPAT-1:0] passed;
  bit odd, qsel, exp_done, forced;
  int qcol [NBITS];
  logic [NBITS-1:0] qdrv [NBITS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NBITS-1:0] drive_for(logic [NBITS-1:0] p, bit plus, bit sel);
    if (plus != sel) return p;
    return ~p;
  endfunction

  task automatic pick_err(input int mode, input int rc, output logic [NBITS-1:0] ep, output logic [NBITS-1:0] en);
    ep = '0; en = '0;
    if (mode == 0 && rc == 0) en = '1;
    else if (mode == 0 && rc == 1) begin ep = 8'h05; en = 8'h0F; end
    else if (mode == 1 && streak == NPAT - 1 && !forced) begin forced = 1; en = 8'h80; end
    else if (rc < ((mode == 2) ? 30 : 12) && ($urandom % 100) < 45) begin
      ep = NBITS'($urandom); en = NBITS'($urandom);
    end
  endtask

  task automatic run_training(input int mode);
    int rc = 0;
    logic [NBITS-1:0] ep, en, any;
    logic [IW-1:0] a;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(wt_init == 1 && busy == 1 && done == 0, "R2 init pulse", {wt_init, busy, done}, 3'b110);
    @(negedge clk);
    chk(wt_init == 0, "R2 single init cycle", wt_init, 0);
    streak = 0; passed = '0; odd = 1; qlen = 0; qhead = 0; exp_done = 0; forced = 0;
    while (1) begin
      @(negedge clk);
      if (upd_valid) begin
        if (qhead < qlen) begin
          chk(int'(upd_col) == qcol[qhead], "R6 column order", upd_col, qcol[qhead]);
          chk(upd_sel == qsel, "R8 matrix select", upd_sel, qsel);
          chk(upd_drive == qdrv[qhead], "R7 drive pattern", upd_drive, qdrv[qhead]);
          qhead++;
        end else chk(0, "R4 unexpected update", upd_col, 0);
      end
      if (rcl_req) begin
        a = pat_addr;
        chk(qhead == qlen, "R6 missing update commands", qhead, qlen);
        chk(int'(a) < NPAT && !passed[a], "R5 learned prototype reselected", a, passed);
        chk(done == 0, "R9 done early", done, 0);
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(rcl_req == 1 && pat_addr == a, "R3 request held", {rcl_req, pat_addr}, {1'b1, a});
        end
        pick_err(mode, rc, ep, en);
        rc++;
        rcl_ack = 1; err_pos = ep; err_neg = en;
        any = ep | en;
        if (any == '0) begin
          passed[a] = 1; streak++;
          if (streak == NPAT) exp_done = 1;
        end else begin
          streak = 0; passed = '0; qsel = !odd; odd = !odd; qlen = 0; qhead = 0;
          for (int j = 0; j < NBITS; j++)
            if (any[j]) begin
              qcol[qlen] = j;
              qdrv[qlen] = drive_for(protos[a], ep[j], qsel);
              qlen++;
            end
        end
        @(negedge clk);
        rcl_ack = 0; err_pos = '0; err_neg = '0;
        chk(rcl_req == 0, "R3 request drops after ack", rcl_req, 0);
        if (upd_valid) begin
          if (qhead < qlen) begin
            chk(int'(upd_col) == qcol[qhead], "R6 column order", upd_col, qcol[qhead]);
            chk(upd_sel == qsel, "R8 matrix select", upd_sel, qsel);
            chk(upd_drive == qdrv[qhead], "R7 drive pattern", upd_drive, qdrv[qhead]);
            qhead++;
          end else chk(0, "R4 unexpected update", upd_col, 0);
        end
        if (exp_done) begin
          chk(done == 1 && busy == 0, "R9 done after full streak", {done, busy}, 2'b10);
          repeat (4) begin
            @(negedge clk);
            chk(done == 1 && rcl_req == 0 && upd_valid == 0, "R9 quiet while done",
                {done, rcl_req, upd_valid}, 3'b100);
          end
          break;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NPAT; i++) protos[i] = NBITS'($urandom);
    rst_n = 0; start = 0; rcl_ack = 0; err_pos = '0; err_neg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({rcl_req, upd_valid, wt_init, busy, done} == 5'b0, "R1 reset state",
        {rcl_req, upd_valid, wt_init, busy, done}, 0);
    fork
      begin
        for (int m = 0; m < 4; m++) run_training(m);
      end
      begin
        wait (cyc >= LIMIT);
        chk(0, "watchdog expired", cyc, LIMIT);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule